// File: doc/BRIEF.md
# Write-and-Verify Cell Programming Controller

This controller brings one resistive memory cell, or a small group of cells programmed side by side, to a target conductance code. It works in rounds. Each round begins with a verify read of the whole group, taken with the gate code at its maximum so that little voltage drops across the access transistor. Every cell still out of its band then gets a programming pulse. A cell below its band gets a set pulse on the bitline terminal. A cell above its band gets a reset pulse on the sourceline terminal. The digital amplitude code steps up from pulse to pulse for as long as the cell keeps moving the same way.

Two step modes are selectable at start. In line-step mode the bitline/sourceline amplitude code climbs while the gate code is held. In gate-step mode the gate code climbs while the line amplitude is held. When the direction of a cell's error flips, that cell's code returns to its starting value. This limits the overshoot and oscillation that a large step would cause. A cell that is still outside its band after the maximum pulse count is marked as failed. The group is complete when every enabled cell is either done or failed. Its pulse count is the largest per-cell count, which is the count of its slowest cell.

The analog pulse drivers and the sense circuit are outside the block. They are reached through two request/acknowledge pairs: one for pulses and one for reads.

Top module: `cell_prog_ctrl`

States and transitions of the sequencer:
- ST_IDLE to ST_READ on `start`.
- ST_READ to ST_EVAL on `read_ack`, which also captures `read_data`.
- ST_EVAL to ST_PULSE if any cell needs a pulse.
- ST_EVAL to ST_IDLE otherwise. This transition raises `group_done`.
- ST_PULSE to ST_READ on `pulse_ack`.

## Requirements
- R1: After reset, `busy`, `group_done`, `read_req`, `pulse_req`, `pulse_fire`, `cell_done` and `cell_fail` are all 0.
- R2: Every round starts with a verify read, including the round before the first pulse. During a read `read_gate` is all ones, and `read_req` and `pulse_req` are never high together.
- R3: A cell whose read value lies in [target-tol, target+tol] (both ends included, lower end floored at 0) gets `cell_done`=1 and receives no further pulse. A cell already inside its band at start finishes with count 0.
- R4: A cell read below its band is fired with `pulse_set`=1 (set, bitline). A cell read above its band is fired with `pulse_set`=0 (reset, sourceline).
- R5: With `step_mode`=0 the cell's `pulse_line` code is START_CODE on its first pulse and rises by STEP_CODE on each further pulse in the same direction, saturating at all ones, while `pulse_gate` holds GATE_HOLD. With `step_mode`=1 the roles of the two codes swap and `pulse_line` holds LINE_HOLD.
- R6: When a cell's pulse direction differs from its previous pulse, its step code restarts at START_CODE.
- R7: A cell that has received MAX_PULSES pulses and still reads out of band gets `cell_fail`=1 and receives no further pulse. Its count never exceeds MAX_PULSES.
- R8: Only cells enabled by `cell_en` at start take part. A disabled cell is never fired and ends with count 0, done 0 and fail 0. `group_done` rises once every enabled cell is done or failed. `group_count` is then the largest `cell_count`. With no cell enabled the group completes after one read, with no pulse.
- R9: `pulse_req` stays high until `pulse_ack` and `read_req` stays high until `read_ack`. Cell i uses bits [i*W +: W] of every packed per-cell bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (accepted when idle) |
| step_mode | input | 1 | 0 = line amplitude steps, 1 = gate code steps |
| cell_en | input | NCELL | Cells that take part in the run |
| target | input | NCELL*G_W | Target conductance code per cell |
| tol | input | G_W | Tolerance half-width, shared by the group |
| read_req | output | 1 | Verify read request |
| read_gate | output | C_W | Gate code used for the read (all ones) |
| read_ack | input | 1 | Read complete, `read_data` valid |
| read_data | input | NCELL*G_W | Conductance code read per cell |
| pulse_req | output | 1 | Programming pulse request |
| pulse_fire | output | NCELL | Cells that receive this pulse |
| pulse_set | output | NCELL | 1 = set on bitline, 0 = reset on sourceline |
| pulse_line | output | NCELL*C_W | Bitline/sourceline amplitude code per cell |
| pulse_gate | output | NCELL*C_W | Gate code per cell |
| pulse_ack | input | 1 | Pulse complete |
| busy | output | 1 | Run in progress |
| group_done | output | 1 | Run finished; held until next start |
| cell_done | output | NCELL | Cell reached its band |
| cell_fail | output | NCELL | Cell hit the pulse limit out of band |
| cell_count | output | NCELL*N_W | Pulses issued per cell |
| group_count | output | N_W | Largest per-cell pulse count |

## Verification
The bench models each cell as a conductance code that a set pulse raises, and a reset pulse lowers, by the stepped code. It runs the controller on five patterns:
- A monotone climb into the band in line-step mode, which isolates the increasing step.
- Gate-step runs in which a cell overshoots and must reverse, which separates the direction restart from plain stepping and, through an oscillating cell, drives the pulse limit.
- A long descent with a disabled neighbour, which shows that the failing cell does not set the count of the idle one.
- A zero-tolerance pair moving in opposite directions, which checks polarity choice per cell.
- Values sitting exactly on and just past the band edge, which tell inclusive from exclusive comparison.

A run with no enabled cell confirms that completion needs no pulse.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EVAL  = 2'd2,
        ST_PULSE = 2'd3
    } cpc_state_e;

    typedef enum logic {
        STEP_LINE = 1'b0,
        STEP_GATE = 1'b1
    } step_mode_e;

endpackage

// File: rtl/cpc_fsm.sv
module cpc_fsm
    import cpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic read_ack,
    input  logic pulse_ack,
    input  logic any_fire,
    output logic load,
    output logic rd_capture,
    output logic eval,
    output logic read_req,
    output logic pulse_req,
    output logic busy,
    output logic group_done
);

    cpc_state_e state_q, state_d;
    logic       done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_READ;
            ST_READ:  if (read_ack)  state_d = ST_EVAL;
            ST_EVAL:  state_d = any_fire ? ST_PULSE : ST_IDLE;
            ST_PULSE: if (pulse_ack) state_d = ST_READ;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                done_q <= 1'b0;
            else if (state_q == ST_EVAL && !any_fire)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        load       = (state_q == ST_IDLE) && start;
        rd_capture = (state_q == ST_READ) && read_ack;
        eval       = (state_q == ST_EVAL);
        read_req   = (state_q == ST_READ);
        pulse_req  = (state_q == ST_PULSE);
        busy       = (state_q != ST_IDLE);
        group_done = done_q;
    end

    a_r9_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req && !pulse_ack |=> pulse_req);
    a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        read_req && !read_ack |=> read_req);
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(read_req && pulse_req));
    a_r2_read_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req && pulse_ack |=> read_req);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        group_done |-> !busy);

endmodule

// File: rtl/cpc_lane.sv
module cpc_lane #(
    parameter int G_W        = 8,
    parameter int C_W        = 6,
    parameter int N_W        = 4,
    parameter int MAX_PULSES = 8,
    parameter int STEP_CODE  = 2,
    parameter int START_CODE = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           en,
    input  logic [G_W-1:0] target,
    input  logic [G_W-1:0] tol,
    input  logic           rd_capture,
    input  logic [G_W-1:0] rd_data,
    input  logic           eval,
    output logic           want_fire,
    output logic           fire,
    output logic           set_dir,
    output logic [C_W-1:0] code,
    output logic [N_W-1:0] count,
    output logic           done,
    output logic           fail
);

    localparam logic [C_W-1:0] CODE_START = C_W'(START_CODE);
    localparam logic [N_W-1:0] CNT_LIMIT  = N_W'(MAX_PULSES);

    logic           active, pulsed;
    logic [G_W-1:0] tgt_q, tol_q, rd_q;
    logic [G_W:0]   band_lo, band_hi;
    logic           below, above, in_band, at_limit, open_lane;
    logic [C_W:0]   code_sum;
    logic [C_W-1:0] code_up;

    always_comb begin
        band_lo   = (tgt_q > tol_q) ? {1'b0, tgt_q - tol_q} : '0;
        band_hi   = {1'b0, tgt_q} + {1'b0, tol_q};
        below     = {1'b0, rd_q} < band_lo;
        above     = {1'b0, rd_q} > band_hi;
        in_band   = !below && !above;
        at_limit  = (count == CNT_LIMIT);
        open_lane = active && !done && !fail;
        want_fire = open_lane && !in_band && !at_limit;
        code_sum  = {1'b0, code} + (C_W+1)'(STEP_CODE);
        code_up   = code_sum[C_W] ? '1 : code_sum[C_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pulsed  <= 1'b0;
            tgt_q   <= '0;
            tol_q   <= '0;
            rd_q    <= '0;
            fire    <= 1'b0;
            set_dir <= 1'b0;
            code    <= CODE_START;
            count   <= '0;
            done    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            if (rd_capture)
                rd_q <= rd_data;
            if (load) begin
                active  <= en;
                pulsed  <= 1'b0;
                tgt_q   <= target;
                tol_q   <= tol;
                fire    <= 1'b0;
                set_dir <= 1'b0;
                code    <= CODE_START;
                count   <= '0;
                done    <= 1'b0;
                fail    <= 1'b0;
            end else if (eval) begin
                fire <= want_fire;
                if (open_lane) begin
                    if (in_band) begin
                        done <= 1'b1;
                    end else if (at_limit) begin
                        fail <= 1'b1;
                    end else begin
                        set_dir <= below;
                        code    <= (!pulsed || set_dir != below) ? CODE_START : code_up;
                        pulsed  <= 1'b1;
                        count   <= count + N_W'(1);
                    end
                end
            end
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_LIMIT);
    a_r3_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done && !load |=> done && !fire);
    a_r7_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !load |=> !fire);
    a_r6_turn_restart: assert property (@(posedge clk) disable iff (!rst_n)
        eval && want_fire && pulsed && (set_dir != below) |=> code == CODE_START);
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        eval && want_fire && pulsed && (set_dir == below) |=> code >= $past(code));

endmodule

// File: rtl/cpc_maxred.sv
module cpc_maxred #(
    parameter int NCELL = 2,
    parameter int N_W   = 4
) (
    input  logic [NCELL*N_W-1:0] counts,
    output logic [N_W-1:0]       max_count
);

    logic [N_W-1:0] chain [NCELL+1];

    assign chain[0] = '0;

    for (genvar i = 0; i < NCELL; i++) begin : g_stage
        logic [N_W-1:0] cur;
        assign cur         = counts[i*N_W +: N_W];
        assign chain[i+1]  = (cur > chain[i]) ? cur : chain[i];
    end

    assign max_count = chain[NCELL];

endmodule

// File: rtl/cell_prog_ctrl.sv
module cell_prog_ctrl
    import cpc_pkg::*;
#(
    parameter int NCELL      = 2,
    parameter int G_W        = 8,
    parameter int C_W        = 6,
    parameter int MAX_PULSES = 8,
    parameter int STEP_CODE  = 2,
    parameter int START_CODE = 4,
    parameter int LINE_HOLD  = 10,
    parameter int GATE_HOLD  = 10,
    localparam int N_W       = $clog2(MAX_PULSES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   step_mode,
    input  logic [NCELL-1:0]       cell_en,
    input  logic [NCELL*G_W-1:0]   target,
    input  logic [G_W-1:0]         tol,
    output logic                   read_req,
    output logic [C_W-1:0]         read_gate,
    input  logic                   read_ack,
    input  logic [NCELL*G_W-1:0]   read_data,
    output logic                   pulse_req,
    output logic [NCELL-1:0]       pulse_fire,
    output logic [NCELL-1:0]       pulse_set,
    output logic [NCELL*C_W-1:0]   pulse_line,
    output logic [NCELL*C_W-1:0]   pulse_gate,
    input  logic                   pulse_ack,
    output logic                   busy,
    output logic                   group_done,
    output logic [NCELL-1:0]       cell_done,
    output logic [NCELL-1:0]       cell_fail,
    output logic [NCELL*N_W-1:0]   cell_count,
    output logic [N_W-1:0]         group_count
);

    localparam logic [C_W-1:0] LINE_FIX = C_W'(LINE_HOLD);
    localparam logic [C_W-1:0] GATE_FIX = C_W'(GATE_HOLD);

    logic             load, rd_capture, eval;
    logic [NCELL-1:0] want_vec, en_q;
    step_mode_e       mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= STEP_LINE;
            en_q   <= '0;
        end else if (load) begin
            mode_q <= step_mode_e'(step_mode);
            en_q   <= cell_en;
        end
    end

    cpc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .read_ack   (read_ack),
        .pulse_ack  (pulse_ack),
        .any_fire   (|want_vec),
        .load       (load),
        .rd_capture (rd_capture),
        .eval       (eval),
        .read_req   (read_req),
        .pulse_req  (pulse_req),
        .busy       (busy),
        .group_done (group_done)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_lane
        logic [C_W-1:0] code;

        cpc_lane #(
            .G_W        (G_W),
            .C_W        (C_W),
            .N_W        (N_W),
            .MAX_PULSES (MAX_PULSES),
            .STEP_CODE  (STEP_CODE),
            .START_CODE (START_CODE)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .en         (cell_en[i]),
            .target     (target[i*G_W +: G_W]),
            .tol        (tol),
            .rd_capture (rd_capture),
            .rd_data    (read_data[i*G_W +: G_W]),
            .eval       (eval),
            .want_fire  (want_vec[i]),
            .fire       (pulse_fire[i]),
            .set_dir    (pulse_set[i]),
            .code       (code),
            .count      (cell_count[i*N_W +: N_W]),
            .done       (cell_done[i]),
            .fail       (cell_fail[i])
        );

        assign pulse_line[i*C_W +: C_W] = (mode_q == STEP_LINE) ? code : LINE_FIX;
        assign pulse_gate[i*C_W +: C_W] = (mode_q == STEP_GATE) ? code : GATE_FIX;
    end

    cpc_maxred #(
        .NCELL (NCELL),
        .N_W   (N_W)
    ) u_maxred (
        .counts    (cell_count),
        .max_count (group_count)
    );

    assign read_gate = '1;

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req |-> (pulse_fire & ~en_q) == '0);
    a_r8_disabled_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ((cell_done | cell_fail) & ~en_q) == '0);
    a_r8_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(group_done) |-> ((cell_done | cell_fail) == en_q));
    a_r2_fire_only_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |-> pulse_fire == '0 || !pulse_req);

endmodule

// File: tb/cell_prog_ctrl_bench.sv
module cell_prog_ctrl_bench;

    localparam int NCELL = 2;
    localparam int G_W   = 8;
    localparam int C_W   = 6;
    localparam int N_W   = 4;
    localparam int HOLD  = 10;

    typedef struct packed {
        logic       mode;
        logic [1:0] en;
        logic [7:0] g0, g1, t0, t1, tol;
        logic [7:0] c0, c1;
        logic [1:0] dmask, fmask;
        logic [7:0] gc, f0, f1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 2'b11, 8'd50,  8'd100, 8'd80, 8'd100, 8'd3, 8'd4, 8'd0, 2'b11, 2'b00, 8'd4, 8'd78,  8'd100},
        '{1'b1, 2'b11, 8'd50,  8'd114, 8'd70, 8'd100, 8'd1, 8'd8, 8'd4, 2'b10, 2'b01, 8'd8, 8'd68,  8'd100},
        '{1'b0, 2'b01, 8'd200, 8'd0,   8'd40, 8'd0,   8'd5, 8'd8, 8'd0, 2'b00, 2'b01, 8'd8, 8'd112, 8'd0},
        '{1'b0, 2'b11, 8'd10,  8'd30,  8'd20, 8'd20,  8'd0, 8'd2, 8'd2, 2'b11, 2'b00, 8'd2, 8'd20,  8'd20},
        '{1'b1, 2'b11, 8'd83,  8'd84,  8'd80, 8'd80,  8'd3, 8'd0, 8'd1, 2'b11, 2'b00, 8'd1, 8'd83,  8'd80}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 step_mode = 1'b0;
    logic [NCELL-1:0]     cell_en = '0;
    logic [NCELL*G_W-1:0] target = '0;
    logic [G_W-1:0]       tol = '0;
    logic                 read_req, read_ack = 1'b0;
    logic [C_W-1:0]       read_gate;
    logic [NCELL*G_W-1:0] read_data = '0;
    logic                 pulse_req, pulse_ack = 1'b0;
    logic [NCELL-1:0]     pulse_fire, pulse_set;
    logic [NCELL*C_W-1:0] pulse_line, pulse_gate;
    logic                 busy, group_done;
    logic [NCELL-1:0]     cell_done, cell_fail;
    logic [NCELL*N_W-1:0] cell_count;
    logic [N_W-1:0]       group_count;

    int checks = 0;
    int errors = 0;
    int gm [NCELL];
    int pulses = 0;
    bit summary_done = 0;

    always #4 clk = ~clk;

    cell_prog_ctrl u_cell_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .step_mode(step_mode),
        .cell_en(cell_en), .target(target), .tol(tol),
        .read_req(read_req), .read_gate(read_gate), .read_ack(read_ack),
        .read_data(read_data), .pulse_req(pulse_req), .pulse_fire(pulse_fire),
        .pulse_set(pulse_set), .pulse_line(pulse_line), .pulse_gate(pulse_gate),
        .pulse_ack(pulse_ack), .busy(busy), .group_done(group_done),
        .cell_done(cell_done), .cell_fail(cell_fail), .cell_count(cell_count),
        .group_count(group_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    endtask

    // Analog side: cell model driven by pulses, answering reads.
    initial begin
        forever begin
            @(negedge clk);
            if (read_req && !read_ack) begin
                chk(read_gate == '1, "R2", "read gate code", read_gate, 63);
                for (int i = 0; i < NCELL; i++)
                    read_data[i*G_W +: G_W] = G_W'(gm[i]);
                read_ack = 1'b1;
                @(negedge clk);
                read_ack = 1'b0;
            end else if (pulse_req && !pulse_ack) begin
                pulses++;
                for (int i = 0; i < NCELL; i++) begin
                    int t, lo, hi, c;
                    bit exp_set;
                    if (pulse_fire[i]) begin
                        t  = int'(target[i*G_W +: G_W]);
                        lo = (t > int'(tol)) ? t - int'(tol) : 0;
                        hi = t + int'(tol);
                        chk(cell_en[i], "R8", "fired disabled cell", 1, 0);
                        chk(gm[i] < lo || gm[i] > hi, "R3", "fired in-band cell", gm[i], t);
                        exp_set = (gm[i] < lo);
                        chk(pulse_set[i] == exp_set, "R4", "pulse polarity",
                            pulse_set[i], exp_set);
                        if (step_mode) begin
                            chk(pulse_line[i*C_W +: C_W] == HOLD, "R5", "line code held",
                                pulse_line[i*C_W +: C_W], HOLD);
                            c = int'(pulse_gate[i*C_W +: C_W]);
                        end else begin
                            chk(pulse_gate[i*C_W +: C_W] == HOLD, "R5", "gate code held",
                                pulse_gate[i*C_W +: C_W], HOLD);
                            c = int'(pulse_line[i*C_W +: C_W]);
                        end
                        gm[i] = pulse_set[i] ? gm[i] + c : gm[i] - c;
                    end
                end
                pulse_ack = 1'b1;
                @(negedge clk);
                pulse_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    task automatic run_group(input logic mode, input logic [1:0] en,
                             input int g0, input int g1, input int t0, input int t1,
                             input int tl);
        int w;
        gm[0] = g0;
        gm[1] = g1;
        step_mode = mode;
        cell_en   = en;
        target    = {G_W'(t1), G_W'(t0)};
        tol       = G_W'(tl);
        pulses    = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!group_done && w < 2000) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle values while and after reset
        chk(!busy && !group_done, "R1", "busy/done in reset", {busy, group_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!read_req && !pulse_req, "R1", "requests idle", {read_req, pulse_req}, 0);
        chk(pulse_fire == '0, "R1", "fire idle", pulse_fire, 0);
        chk(cell_done == '0 && cell_fail == '0, "R1", "status idle",
            {cell_done, cell_fail}, 0);

        for (int v = 0; v < 5; v++) begin
            vec_t x;
            x = VECS[v];
            run_group(x.mode, x.en, int'(x.g0), int'(x.g1), int'(x.t0), int'(x.t1),
                      int'(x.tol));
            chk(group_done, "R8", $sformatf("v%0d group done", v), group_done, 1);
            chk(!busy, "R8", $sformatf("v%0d idle after done", v), busy, 0);
            chk(cell_count[0 +: N_W] == x.c0[N_W-1:0], "R5",
                $sformatf("v%0d cell0 count", v), cell_count[0 +: N_W], x.c0);
            chk(cell_count[N_W +: N_W] == x.c1[N_W-1:0], "R6",
                $sformatf("v%0d cell1 count", v), cell_count[N_W +: N_W], x.c1);
            chk(cell_done == x.dmask, "R3", $sformatf("v%0d done mask", v),
                cell_done, x.dmask);
            chk(cell_fail == x.fmask, "R7", $sformatf("v%0d fail mask", v),
                cell_fail, x.fmask);
            chk(group_count == x.gc[N_W-1:0], "R8", $sformatf("v%0d group count", v),
                group_count, x.gc);
            chk(gm[0] == int'(x.f0), "R6", $sformatf("v%0d cell0 final", v), gm[0], x.f0);
            chk(gm[1] == int'(x.f1), "R4", $sformatf("v%0d cell1 final", v), gm[1], x.f1);
        end

        // R8: no enabled cell completes after one read with no pulse
        run_group(1'b0, 2'b00, 5, 5, 90, 90, 1);
        chk(group_done, "R8", "empty group done", group_done, 1);
        chk(pulses == 0, "R8", "empty group pulses", pulses, 0);
        chk(group_count == '0, "R8", "empty group count", group_count, 0);
        chk(gm[0] == 5 && gm[1] == 5, "R8", "empty group cells untouched", gm[0], 5);

        // R7: pulse limit counted in vector 2; confirm restart clears flags
        run_group(1'b0, 2'b01, 60, 0, 60, 0, 0);
        chk(cell_fail == '0 && cell_done == 2'b01, "R7", "flags cleared on new run",
            {cell_fail, cell_done}, 1);

        summary();
    end

endmodule